// File: doc/BRIEF.md
# Ethernet PHY LED Behaviour Controller

This block turns the status of an Ethernet PHY into the drive for a small row of indicator LEDs. Every LED owns two 8-bit configuration words. They name one condition that keeps the LED steadily lit, one that makes it blink at the global fast rate, one that makes it blink at the global slow rate, and a mask of traffic events that flash it. Two global words hold the fast and slow blink rates, plus some further condition fields that are stored and read back but drive nothing.

A free-running timebase built from the system clock supplies the blink waveforms, so every LED that uses the same rate toggles in step. A traffic event is stretched into an on period of fixed length followed by a dark gap of the same length, which keeps continuous traffic visible as flashing. Software writes the words through a plain register port with single-cycle writes and combinational reads. The output polarity is chosen by a parameter.

Top module: `phy_led_ctrl`

## Requirements
- R1: Address map: 0 is global word A, 1 is global word B, 2+2i is the high word of LED i and 3+2i is its low word. After reset they read A=0x00C5, B=0x0067, high words 0x70, 0x20, 0x40, 0x40 and low words 0x03, 0x00, 0x00, 0x20 for LEDs 0 to 3. Reset is asynchronous on assertion and takes effect two clocks after `rst_ni` rises.
- R2: A write changes the word from the next clock edge. Reads are combinational. Bits 15:8 always read zero, word A reads bit 3 as zero, word B reads bits 7 and 3 as zero, and unmapped addresses read zero and ignore writes.
- R3: The constant-on selector sits in bits 7:4 of the high word. Code 0 never lights. For codes 1 to 7 the LED is lit while the link is up at a speed whose bit is set in the code (bit0 is 10, bit1 is 100 and bit2 is 1000 Mbit/s).
- R4: The fast-blink selector sits in bits 3:0 of the high word and the slow-blink selector in bits 7:4 of the low word. While the selected condition holds, the LED follows a 50% duty square wave. Word A bits 7:6 set the fast rate and bits 5:4 set the slow rate, with codes 0 to 3 giving 2, 4, 8 and 16 Hz.
- R5: Selector codes 8, 9, A, B and C select power-down, EEE mode, auto-negotiation running, self-test running and cable diagnostics running. Codes D to F never match.
- R6: The pulse mask sits in bits 3:0 of the low word, with bit0 for transmit, bit1 for receive and bit2 for collision. When any selected event is seen while idle, the LED is lit for PULSE_CYC cycles and then held dark for PULSE_CYC cycles, and events during that time are not counted.
- R7: Bit 3 of the pulse mask has no effect on the LED.
- R8: The pulse has the highest priority, then fast blink, then slow blink, then constant-on. If none applies, the LED is dark.
- R9: With ACTIVE_LOW=1 every LED output is the inverse of the ACTIVE_LOW=0 output.
- R10: A link speed code of 3 matches no speed bit.
- R11: Timebase: after k active clock edges the tick count is floor(k/(CLK_HZ/32)) mod 16. The wave for rate code r is bit (3-r) of that count, and the LED is lit while that bit is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| link_up_i | input | 1 | Link established |
| link_speed_i | input | 2 | 0=10, 1=100, 2=1000 Mbit/s, 3=none |
| pwr_down_i | input | 1 | PHY powered down |
| eee_i | input | 1 | Energy-efficient mode active |
| aneg_i | input | 1 | Auto-negotiation running |
| selftest_i | input | 1 | Analog self-test running |
| cablediag_i | input | 1 | Cable diagnostics running |
| tx_act_i | input | 1 | Transmit activity |
| rx_act_i | input | 1 | Receive activity |
| col_i | input | 1 | Collision |
| led_o | output | NUM_LEDS | LED drive |

## Verification
On every cycle the assertions check that the blink waves move only on a timebase tick, that a write can be read back on the following cycle, and that stored words hold when nothing is written. They also check that a stretched pulse begins only after a selected event, that the dark gap cannot be cut short, and that a mask holding only the reserved bit never starts a pulse. The decoding of condition codes, the priority between the four sources, the blink phase and rates, the reset values and the polarity option can only be shown by the bench. It compares every LED and the read port on every cycle against its own model, using random configurations and status together with directed cases.

// File: rtl/led_ctl_pkg.sv
package led_ctl_pkg;

  localparam int SEL_W  = 4;
  localparam int RATE_W = 2;
  localparam int TICK_W = 4;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic       link_up;
    logic [1:0] speed;
    logic       pwr_down;
    logic       eee;
    logic       aneg;
    logic       selftest;
    logic       cablediag;
  } phy_stat_t;

  typedef struct packed {
    logic [SEL_W-1:0] on_sel;
    logic [SEL_W-1:0] fast_sel;
    logic [SEL_W-1:0] slow_sel;
    logic [SEL_W-1:0] pulse_mask;
  } lane_cfg_t;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ON = 2'd1, ST_GAP = 2'd2} stretch_st_e;

  // Shared condition decoder for all three selector kinds.
  function automatic logic cond_hit(input logic [SEL_W-1:0] sel, input phy_stat_t s);
    logic hit;
    hit = 1'b0;
    if (sel >= 4'h1 && sel <= 4'h7) begin
      hit = s.link_up && (s.speed != 2'd3) && sel[s.speed];
    end else begin
      case (sel)
        4'h8:    hit = s.pwr_down;
        4'h9:    hit = s.eee;
        4'hA:    hit = s.aneg;
        4'hB:    hit = s.selftest;
        4'hC:    hit = s.cablediag;
        default: hit = 1'b0;
      endcase
    end
    return hit;
  endfunction

  function automatic logic [7:0] hi_reset(input int idx);
    case (idx)
      0:       return 8'h70;
      1:       return 8'h20;
      2:       return 8'h40;
      3:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] lo_reset(input int idx);
    case (idx)
      0:       return 8'h03;
      3:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/led_timebase.sv
module led_timebase #(
  parameter int CLK_HZ  = 25_000_000,
  parameter int TICK_HZ = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  output logic [led_ctl_pkg::TICK_W-1:0] wave_o
);
  import led_ctl_pkg::*;

  localparam int DIV   = (CLK_HZ / TICK_HZ) > 1 ? (CLK_HZ / TICK_HZ) : 1;
  localparam int PRE_W = DIV > 1 ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic              tick_en;

  always_comb begin
    tick_en = (pre_q == PRE_LAST);
    pre_d   = tick_en ? '0 : pre_q + 1'b1;
    tick_d  = tick_q;
    if (tick_en) begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else begin
      pre_q <= pre_d;
      if (tick_en) begin
        tick_q <= tick_d;
      end
    end
  end

  // Rate code r picks tick bit (TICK_W-1-r): code 0 slowest.
  for (genvar r = 0; r < TICK_W; r++) begin : g_wave
    assign wave_o[r] = tick_q[TICK_W-1-r];
  end

  AST_WAVE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en |=> $stable(wave_o)); // R11

endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs #(
  parameter int NUM_LEDS = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [led_ctl_pkg::WORD_W-1:0]   wdata_i,
  output logic [led_ctl_pkg::WORD_W-1:0]   rdata_o,
  output logic [led_ctl_pkg::RATE_W-1:0]   fast_rate_o,
  output logic [led_ctl_pkg::RATE_W-1:0]   slow_rate_o,
  output led_ctl_pkg::lane_cfg_t           cfg_o [NUM_LEDS]
);
  import led_ctl_pkg::*;

  localparam logic [7:0] GA_MASK  = 8'hF7;
  localparam logic [7:0] GB_MASK  = 8'h77;
  localparam logic [7:0] GA_RESET = 8'hC5;
  localparam logic [7:0] GB_RESET = 8'h67;

  logic [7:0] ga_q, ga_d, gb_q, gb_d;
  logic [NUM_LEDS-1:0][7:0] hi_q, hi_d, lo_q, lo_d;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i[WORD_W-1:8];

  always_comb begin
    ga_d = ga_q;
    gb_d = gb_q;
    if (we_i && addr_i == ADDR_W'(0)) ga_d = wdata_i[7:0] & GA_MASK;
    if (we_i && addr_i == ADDR_W'(1)) gb_d = wdata_i[7:0] & GB_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ga_q <= GA_RESET;
      gb_q <= GB_RESET;
    end else begin
      ga_q <= ga_d;
      gb_q <= gb_d;
    end
  end

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_lane
    localparam logic [7:0] HI_RST = hi_reset(g);
    localparam logic [7:0] LO_RST = lo_reset(g);
    logic hi_we, lo_we;

    assign hi_we = we_i && (addr_i == ADDR_W'(2 + 2*g));
    assign lo_we = we_i && (addr_i == ADDR_W'(3 + 2*g));

    always_comb begin
      hi_d[g] = hi_we ? wdata_i[7:0] : hi_q[g];
      lo_d[g] = lo_we ? wdata_i[7:0] : lo_q[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q[g] <= HI_RST;
        lo_q[g] <= LO_RST;
      end else begin
        if (hi_we) hi_q[g] <= hi_d[g];
        if (lo_we) lo_q[g] <= lo_d[g];
      end
    end

    always_comb begin
      cfg_o[g].on_sel     = hi_q[g][7:4];
      cfg_o[g].fast_sel   = hi_q[g][3:0];
      cfg_o[g].slow_sel   = lo_q[g][7:4];
      cfg_o[g].pulse_mask = lo_q[g][3:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(0)) rdata_o[7:0] = ga_q;
    if (addr_i == ADDR_W'(1)) rdata_o[7:0] = gb_q;
    for (int i = 0; i < NUM_LEDS; i++) begin
      if (addr_i == ADDR_W'(2 + 2*i)) rdata_o[7:0] = hi_q[i];
      if (addr_i == ADDR_W'(3 + 2*i)) rdata_o[7:0] = lo_q[i];
    end
  end

  assign fast_rate_o = ga_q[7:6];
  assign slow_rate_o = ga_q[5:4];

  AST_RAW_LED0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(2)) |=> (addr_i != ADDR_W'(2)) || (rdata_o[7:0] == $past(wdata_i[7:0]))); // R2

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(hi_q) && $stable(lo_q) && $stable(ga_q) && $stable(gb_q))); // R2

endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch #(
  parameter int PULSE_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic on_o,
  output logic busy_o
);
  import led_ctl_pkg::*;

  localparam int CNT_W = PULSE_CYC > 1 ? $clog2(PULSE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYC - 1);

  stretch_st_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (evt_i) begin
          st_d  = ST_ON;
          cnt_d = CNT_LAST;
        end
      end
      ST_ON: begin
        if (cnt_q == '0) begin
          st_d  = ST_GAP;
          cnt_d = CNT_LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == '0) st_d = ST_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign on_o   = (st_q == ST_ON);
  assign busy_o = (st_q != ST_IDLE);

  AST_GAP_DEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GAP && cnt_q != '0) |=> (st_q == ST_GAP)); // R6

  AST_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(on_o) |-> $past(evt_i)); // R6

endmodule

// File: rtl/led_lane.sv
module led_lane #(
  parameter int PULSE_CYC  = 1,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  led_ctl_pkg::lane_cfg_t cfg_i,
  input  led_ctl_pkg::phy_stat_t stat_i,
  input  logic [2:0]             evt_i,
  input  logic                   fast_wave_i,
  input  logic                   slow_wave_i,
  output logic                   led_o
);
  import led_ctl_pkg::*;

  logic evt_sel, pulse_on, pulse_busy, lit;
  logic unused_rsvd;

  assign unused_rsvd = cfg_i.pulse_mask[3];
  assign evt_sel     = |(cfg_i.pulse_mask[2:0] & evt_i);

  led_pulse_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_sel),
    .on_o   (pulse_on),
    .busy_o (pulse_busy)
  );

  always_comb begin
    if (pulse_busy)                           lit = pulse_on;
    else if (cond_hit(cfg_i.fast_sel, stat_i)) lit = fast_wave_i;
    else if (cond_hit(cfg_i.slow_sel, stat_i)) lit = slow_wave_i;
    else                                       lit = cond_hit(cfg_i.on_sel, stat_i);
  end

  if (ACTIVE_LOW) begin : g_inv
    assign led_o = ~lit;
  end else begin : g_dir
    assign led_o = lit;
  end

  AST_MASK_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_busy && ((cfg_i.pulse_mask[2:0] & evt_i) == 3'b000)) |=> !pulse_busy); // R7

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl #(
  parameter int NUM_LEDS   = 4,
  parameter int ADDR_W     = 4,
  parameter int CLK_HZ     = 25_000_000,
  parameter int PULSE_MS   = 40,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [15:0]         reg_wdata_i,
  output logic [15:0]         reg_rdata_o,
  input  logic                link_up_i,
  input  logic [1:0]          link_speed_i,
  input  logic                pwr_down_i,
  input  logic                eee_i,
  input  logic                aneg_i,
  input  logic                selftest_i,
  input  logic                cablediag_i,
  input  logic                tx_act_i,
  input  logic                rx_act_i,
  input  logic                col_i,
  output logic [NUM_LEDS-1:0] led_o
);
  import led_ctl_pkg::*;

  localparam int PULSE_RAW = (CLK_HZ * PULSE_MS) / 1000;
  localparam int PULSE_CYC = PULSE_RAW > 1 ? PULSE_RAW : 1;

  logic [1:0]        sync_q;
  logic              rst_int_n;
  logic [TICK_W-1:0] wave;
  logic [RATE_W-1:0] fast_rate, slow_rate;
  logic              fast_wave, slow_wave;
  lane_cfg_t         cfg [NUM_LEDS];
  phy_stat_t         stat;
  logic [2:0]        evt;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  always_comb begin
    stat.link_up   = link_up_i;
    stat.speed     = link_speed_i;
    stat.pwr_down  = pwr_down_i;
    stat.eee       = eee_i;
    stat.aneg      = aneg_i;
    stat.selftest  = selftest_i;
    stat.cablediag = cablediag_i;
  end
  assign evt = {col_i, rx_act_i, tx_act_i};

  led_timebase #(.CLK_HZ(CLK_HZ), .TICK_HZ(32)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .wave_o (wave)
  );

  led_cfg_regs #(.NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .fast_rate_o (fast_rate),
    .slow_rate_o (slow_rate),
    .cfg_o       (cfg)
  );

  assign fast_wave = wave[fast_rate];
  assign slow_wave = wave[slow_rate];

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
    led_lane #(.PULSE_CYC(PULSE_CYC), .ACTIVE_LOW(ACTIVE_LOW)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_int_n),
      .cfg_i       (cfg[g]),
      .stat_i      (stat),
      .evt_i       (evt),
      .fast_wave_i (fast_wave),
      .slow_wave_i (slow_wave),
      .led_o       (led_o[g])
    );
  end

endmodule

// File: tb/phy_led_ctrl_tb_top.sv
module phy_led_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 640;
  localparam int NL         = 4;
  localparam int DIV        = CLK_HZ / 32;
  localparam int PC         = (CLK_HZ * 40) / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic link = 0, pd = 0, eee = 0, an = 0, st = 0, cd = 0, tx = 0, rx = 0, col = 0;
  logic [1:0] spd = 2'd0;
  logic [NL-1:0] led, led_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0, model_live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_led_ctrl #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .link_up_i(link),
    .link_speed_i(spd), .pwr_down_i(pd), .eee_i(eee), .aneg_i(an),
    .selftest_i(st), .cablediag_i(cd), .tx_act_i(tx), .rx_act_i(rx),
    .col_i(col), .led_o(led));

  logic [15:0] rdata_n;
  phy_led_ctrl #(.CLK_HZ(CLK_HZ), .ACTIVE_LOW(1'b1)) dut_inv_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_n), .link_up_i(link),
    .link_speed_i(spd), .pwr_down_i(pd), .eee_i(eee), .aneg_i(an),
    .selftest_i(st), .cablediag_i(cd), .tx_act_i(tx), .rx_act_i(rx),
    .col_i(col), .led_o(led_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=0x%0h expected=0x%0h", req, $time, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_ga, m_gb;
  logic [7:0] m_hi [NL];
  logic [7:0] m_lo [NL];
  int m_st [NL];
  int m_cnt [NL];
  bit m_s0, m_s1;
  int m_act;

  function automatic bit m_cond(input logic [3:0] sel);
    if (sel >= 4'h1 && sel <= 4'h7) return link && (spd != 2'd3) && sel[spd];
    case (sel)
      4'h8: return pd;
      4'h9: return eee;
      4'hA: return an;
      4'hB: return st;
      4'hC: return cd;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_wave(input logic [1:0] rate);
    int tick;
    tick = (m_act / DIV) % 16;
    return tick[3 - rate];
  endfunction

  function automatic bit m_led(input int i, output string tag);
    if (m_st[i] != 0) begin tag = "R6/R8 pulse"; return m_st[i] == 1; end
    if (m_cond(m_hi[i][3:0])) begin tag = "R4/R11 fast"; return m_wave(m_ga[7:6]); end
    if (m_cond(m_lo[i][7:4])) begin tag = "R4/R11 slow"; return m_wave(m_ga[5:4]); end
    tag = "R3/R5 const";
    return m_cond(m_hi[i][7:4]);
  endfunction

  function automatic logic [15:0] m_rd(input logic [3:0] a);
    if (a == 4'd0) return {8'h00, m_ga};
    if (a == 4'd1) return {8'h00, m_gb};
    if (a >= 4'd2 && a < 4'(2 + 2*NL)) begin
      if (a[0]) return {8'h00, m_lo[(a - 3) / 2]};
      return {8'h00, m_hi[(a - 2) / 2]};
    end
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_act = 0;
      m_ga = 8'hC5; m_gb = 8'h67;
      m_hi[0] = 8'h70; m_hi[1] = 8'h20; m_hi[2] = 8'h40; m_hi[3] = 8'h40;
      m_lo[0] = 8'h03; m_lo[1] = 8'h00; m_lo[2] = 8'h00; m_lo[3] = 8'h20;
      for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
      model_live = 1;
    end else begin
      if (m_s1) begin
        for (int i = 0; i < NL; i++) begin
          bit ev;
          ev = |(m_lo[i][2:0] & {col, rx, tx});
          case (m_st[i])
            0: if (ev) begin m_st[i] = 1; m_cnt[i] = PC - 1; end
            1: if (m_cnt[i] == 0) begin m_st[i] = 2; m_cnt[i] = PC - 1; end
               else m_cnt[i]--;
            default: if (m_cnt[i] == 0) m_st[i] = 0; else m_cnt[i]--;
          endcase
        end
        if (we) begin
          if (addr == 4'd0) m_ga = wdata[7:0] & 8'hF7;
          else if (addr == 4'd1) m_gb = wdata[7:0] & 8'h77;
          else if (addr >= 4'd2 && addr < 4'(2 + 2*NL)) begin
            if (addr[0]) m_lo[(addr - 3) / 2] = wdata[7:0];
            else         m_hi[(addr - 2) / 2] = wdata[7:0];
          end
        end
        m_act++;
      end
      m_s1 = m_s0; m_s0 = 1;
    end
  end

  // Continuous comparison, away from the active edge.
  always @(negedge clk) begin
    #3;
    if (model_live && !done) begin
      for (int i = 0; i < NL; i++) begin
        string tag;
        bit e;
        e = m_led(i, tag);
        check(led[i] == e, tag, int'(led[i]), int'(e));
        check(led_n[i] == !e, "R9 active-low", int'(led_n[i]), int'(!e));
      end
      check(rdata == m_rd(addr), "R2 read", int'(rdata), int'(m_rd(addr)));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] rst_vals [10];
    rst_vals = '{16'h00C5, 16'h0067, 16'h0070, 16'h0003, 16'h0020,
                 16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0020};
    void'($urandom(32'h1D5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset contents, checked against literal values
    for (int a = 0; a < 10; a++) begin
      @(negedge clk); addr = 4'(a); #3;
      check(rdata == rst_vals[a], "R1 reset word", int'(rdata), int'(rst_vals[a]));
    end
    @(negedge clk); addr = 4'd12; #3;
    check(rdata == 16'h0, "R2 unmapped read", int'(rdata), 0);

    // R2: reserved bits and unmapped writes
    wr(4'd0, 16'hFFFF);
    @(negedge clk); addr = 4'd0; #3;
    check(rdata == 16'h00F7, "R2 global A mask", int'(rdata), 16'h00F7);
    wr(4'd1, 16'hFFFF);
    @(negedge clk); addr = 4'd1; #3;
    check(rdata == 16'h0077, "R2 global B mask", int'(rdata), 16'h0077);
    wr(4'd13, 16'h00AA);
    @(negedge clk); addr = 4'd13; #3;
    check(rdata == 16'h0000, "R2 unmapped write", int'(rdata), 0);
    wr(4'd0, 16'h00C5);

    // R3: link 1000 lights LED0 (0x7) and LED2 (0x4)
    @(negedge clk); link = 1; spd = 2'd2; #3;
    check(led[0] == 1'b1, "R3 LED0 at 1000", int'(led[0]), 1);
    check(led[1] == 1'b0, "R3 LED1 at 1000", int'(led[1]), 0);
    check(led[2] == 1'b1, "R3 LED2 at 1000", int'(led[2]), 1);

    // R10: speed code 3 matches nothing
    @(negedge clk); spd = 2'd3; #3;
    check(led[0] == 1'b0, "R10 speed code 3", int'(led[0]), 0);
    @(negedge clk); spd = 2'd2;

    // R6 / R8: tx pulse overrides constant-on on LED0
    @(negedge clk); tx = 1;
    @(negedge clk); tx = 0; #3;
    check(led[0] == 1'b1, "R6 pulse first", int'(led[0]), 1);
    for (int k = 2; k <= 2*PC + 1; k++) begin
      @(negedge clk);
      if (k == PC / 2) tx = 1;
      if (k == PC + 3) tx = 0;
      #3;
      if (k == PC)     check(led[0] == 1'b1, "R6 pulse last on", int'(led[0]), 1);
      if (k == PC + 1) check(led[0] == 1'b0, "R8 gap over const", int'(led[0]), 0);
      if (k == 2*PC)   check(led[0] == 1'b0, "R6 gap last", int'(led[0]), 0);
    end
    tx = 0;
    repeat (2) @(negedge clk);

    // R7: mask with only bit 3 never pulses
    wr(4'd4, 16'h0000);
    wr(4'd5, 16'h0008);
    @(negedge clk); tx = 1; rx = 1; col = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #3;
      check(led[1] == 1'b0, "R7 reserved mask bit", int'(led[1]), 0);
    end
    tx = 0; rx = 0; col = 0;

    // R5: code D never matches, code A follows auto-negotiation
    wr(4'd6, 16'h00D0);
    @(negedge clk); an = 1; #3;
    check(led[2] == 1'b0, "R5 code D", int'(led[2]), 0);
    wr(4'd6, 16'h00A0);
    @(negedge clk); #3;
    check(led[2] == 1'b1, "R5 code A", int'(led[2]), 1);

    // Random phase; the continuous comparison checks every cycle.
    for (int c = 0; c < 16000; c++) begin
      @(negedge clk);
      we = 0;
      addr = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 39) == 0) begin
        we = 1;
        wdata = 16'($urandom);
      end
      if ($urandom_range(0, 149) == 0) begin
        link = 1'($urandom); spd = 2'($urandom);
        pd = 1'($urandom); eee = 1'($urandom); an = 1'($urandom);
        st = 1'($urandom); cd = 1'($urandom);
      end
      tx  = ($urandom_range(0, 29) == 0);
      rx  = ($urandom_range(0, 29) == 0);
      col = ($urandom_range(0, 79) == 0);
    end
    @(negedge clk); we = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule